// File: doc/BRIEF.md
# Packed Signed Greater-Than Unit

This execution unit compares two packed operands lane by lane as two's-complement integers. The element size is picked per operation: 8, 16 or 32 bits. The operation width is also picked per operation: 64 or 128 bits. Each result lane is all ones when the destination element is strictly greater than the source element at the same bit position, and all zeros otherwise.

The unit accepts one operation per cycle. The inputs are qualified by a valid strobe, and the result comes back from a register exactly one cycle later. It produces no condition flags and no numeric exceptions. The one exception is the reserved element-size code: that code yields an all-zero result and raises an error flag.

Top module: `pgt_unit`

## Requirements
- R1: With `in_esize` = 2'b00 (byte), each 8-bit lane of `out_result` is 8'hFF when the signed destination byte is strictly greater than the signed source byte, and 8'h00 otherwise.
- R2: With `in_esize` = 2'b01 (word), each 16-bit lane is 16'hFFFF or 16'h0000 according to a signed 16-bit greater-than. Carries across byte boundaries inside the lane are honoured.
- R3: With `in_esize` = 2'b10 (doubleword), each 32-bit lane is 32'hFFFFFFFF or 32'h0 according to a signed 32-bit greater-than.
- R4: Lanes whose destination and source elements are equal give all zeros.
- R5: The comparison is signed. The most negative value compared with the largest positive value gives zeros, and the reverse gives ones.
- R6: With `in_wide` = 0 (64-bit width), only bits 63:0 of the operands take part, and `out_result[127:64]` is zero.
- R7: With `in_wide` = 1 (128-bit width), all 16, 8 or 4 lanes across bits 127:0 are compared.
- R8: `in_esize` = 2'b11 is reserved. It yields `out_result` = 0 and `out_bad_size` = 1. Valid sizes give `out_bad_size` = 0.
- R9: `out_valid` equals `in_valid` delayed by exactly one cycle. Operations on consecutive cycles each produce their own result.
- R10: Synchronous active-high reset clears `out_valid`, `out_result` and `out_bad_size`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_dst | input | 128 | Destination operand (left side of the compare) |
| in_src | input | 128 | Source operand (right side of the compare) |
| in_esize | input | 2 | Element size: 00 byte, 01 word, 10 doubleword, 11 reserved |
| in_wide | input | 1 | 1 = 128-bit width, 0 = 64-bit width |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 128 | Per-lane mask result |
| out_bad_size | output | 1 | Reserved element-size code seen |

## Verification
One operand pair mixes equal bytes, lanes one step apart, and sign-boundary pairs 80h/7Fh. Run at byte size, it separates a signed compare from an unsigned one and strict from non-strict greater-than. The word and doubleword pairs include elements such as 0080h against 007Fh, whose answer differs from the answer the low byte alone would give, so a wrong lane boundary is exposed. Every pair is also run at 64-bit width with nonzero upper halves, to show that the upper operands are ignored and the upper result is cleared. The reserved size code, fully equal operands and back-to-back issue are tested separately.

// File: rtl/pgt_pkg.sv
package pgt_pkg;

    localparam int VEC_W  = 128;
    localparam int HALF_W = VEC_W / 2;

    typedef enum logic [1:0] {
        ESZ_BYTE  = 2'b00,
        ESZ_WORD  = 2'b01,
        ESZ_DWORD = 2'b10,
        ESZ_RSVD  = 2'b11
    } esize_e;

    typedef struct packed {
        logic             bad;
        logic [VEC_W-1:0] mask;
    } pgt_res_t;

    function automatic logic [VEC_W-1:0] low_half_keep(input logic wide);
        return wide ? {VEC_W{1'b1}} : {{(VEC_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    endfunction

endpackage

// File: rtl/pgt_lane_bank.sv
module pgt_lane_bank #(
    parameter int VEC_W  = 128,
    parameter int ELEM_W = 8
) (
    input  logic [VEC_W-1:0] dst,
    input  logic [VEC_W-1:0] src,
    output logic [VEC_W-1:0] mask
);
    localparam int LANES = VEC_W / ELEM_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [ELEM_W-1:0] d_el;
        logic signed [ELEM_W-1:0] s_el;
        assign d_el = dst[g*ELEM_W +: ELEM_W];
        assign s_el = src[g*ELEM_W +: ELEM_W];
        assign mask[g*ELEM_W +: ELEM_W] = {ELEM_W{d_el > s_el}};
    end
endmodule

// File: rtl/pgt_mask_select.sv
module pgt_mask_select
    import pgt_pkg::*;
(
    input  logic [VEC_W-1:0] mask_b,
    input  logic [VEC_W-1:0] mask_w,
    input  logic [VEC_W-1:0] mask_d,
    input  esize_e           esize,
    input  logic             wide,
    output pgt_res_t         res
);
    logic [VEC_W-1:0] picked;

    always_comb begin
        res.bad = 1'b0;
        unique case (esize)
            ESZ_BYTE:  picked = mask_b;
            ESZ_WORD:  picked = mask_w;
            ESZ_DWORD: picked = mask_d;
            default: begin
                picked  = '0;
                res.bad = 1'b1;
            end
        endcase
        res.mask = picked & low_half_keep(wide);
    end
endmodule

// File: rtl/pgt_unit.sv
module pgt_unit
    import pgt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [127:0]     in_dst,
    input  logic [127:0]     in_src,
    input  logic [1:0]       in_esize,
    input  logic             in_wide,
    output logic             out_valid,
    output logic [127:0]     out_result,
    output logic             out_bad_size
);
    localparam int B_W = 8;
    localparam int W_W = 16;
    localparam int D_W = 32;
    localparam int N_D = VEC_W / D_W;

    logic [VEC_W-1:0] m_b, m_w, m_d;
    pgt_res_t         sel;

    pgt_lane_bank #(.VEC_W(VEC_W), .ELEM_W(B_W)) u_bank_b (.dst(in_dst), .src(in_src), .mask(m_b));
    pgt_lane_bank #(.VEC_W(VEC_W), .ELEM_W(W_W)) u_bank_w (.dst(in_dst), .src(in_src), .mask(m_w));
    pgt_lane_bank #(.VEC_W(VEC_W), .ELEM_W(D_W)) u_bank_d (.dst(in_dst), .src(in_src), .mask(m_d));

    pgt_mask_select u_sel (
        .mask_b (m_b),
        .mask_w (m_w),
        .mask_d (m_d),
        .esize  (esize_e'(in_esize)),
        .wide   (in_wide),
        .res    (sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_result   <= '0;
            out_bad_size <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result   <= sel.mask;
                out_bad_size <= sel.bad;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R9
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R9
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_wide) |=> (out_result[127:64] == '0)); // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_esize == 2'b11) |=> (out_bad_size && out_result == '0)); // R8
    AST_EQUAL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dst == in_src) |=> (out_result == '0)); // R4

    for (genvar k = 0; k < N_D; k++) begin : g_chk
        AST_DWORD_UNIFORM: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_esize == 2'b10) |=>
            (out_result[k*D_W +: D_W] == '0 || out_result[k*D_W +: D_W] == '1)); // R3
    end
endmodule

// File: tb/sim_pgt_unit.sv
`timescale 1ns/1ps
module sim_pgt_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] in_dst, in_src;
    logic [1:0]   in_esize;
    logic         in_wide;
    logic         out_valid;
    logic [127:0] out_result;
    logic         out_bad_size;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    pgt_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dst(in_dst), .in_src(in_src),
        .in_esize(in_esize), .in_wide(in_wide), .out_valid(out_valid),
        .out_result(out_result), .out_bad_size(out_bad_size)
    );

    localparam int NV = 8;
    localparam logic [127:0] T_DST [NV] = '{
        128'h01807F00FF102030_01807F00FF102030,
        128'h01807F00FF102030_01807F00FF102030,
        128'h80007FFF0001FFFF_1234123401000080,
        128'h80007FFF0001FFFF_1234123401000080,
        128'h800000007FFFFFFF_00008000FFFFFFFE,
        128'h800000007FFFFFFF_00008000FFFFFFFE,
        128'h7F7F7F7F7F7F7F7F_7F7F7F7F7F7F7F7F,
        128'hDEADBEEF01234567_89ABCDEF80000000};
    localparam logic [127:0] T_SRC [NV] = '{
        128'h007F80000010212F_007F80000010212F,
        128'h007F80000010212F_007F80000010212F,
        128'h7FFF800000000000_1234123300FF007F,
        128'h7FFF800000000000_1234123300FF007F,
        128'h7FFFFFFF80000000_00007FFFFFFFFFFF,
        128'h7FFFFFFF80000000_00007FFFFFFFFFFF,
        128'h0,
        128'hDEADBEEF01234567_89ABCDEF80000000};
    localparam logic [1:0] T_ESZ [NV] = '{2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10, 2'b11, 2'b10};
    localparam logic       T_WIDE[NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic [127:0] T_EXP [NV] = '{
        128'hFF00FF00000000FF_FF00FF00000000FF,
        128'h0000000000000000_FF00FF00000000FF,
        128'h0000FFFFFFFF0000_0000FFFFFFFFFFFF,
        128'h0000000000000000_0000FFFFFFFFFFFF,
        128'h00000000FFFFFFFF_FFFFFFFF00000000,
        128'h0000000000000000_FFFFFFFF00000000,
        128'h0,
        128'h0};
    localparam logic T_BAD [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam string T_REQ [NV] = '{"R1 R5 R7", "R1 R6", "R2 R5 R7", "R2 R6",
                                     "R3 R5 R7", "R3 R6", "R8", "R4 R3"};

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [127:0] d, input logic [127:0] s,
                         input logic [1:0] e, input logic w);
        in_valid = v; in_dst = d; in_src = s; in_esize = e; in_wide = w;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(1'b1, '1, '0, 2'b00, 1'b1);
        repeat (3) @(posedge clk);
        #1;
        chk("R10 valid", {127'b0, out_valid}, 128'h0);
        chk("R10 result", out_result, 128'h0);
        chk("R10 bad", {127'b0, out_bad_size}, 128'h0);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, '0, '0, 2'b00, 1'b1);

        // table walked back-to-back: valid held high across entries (R9)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(1'b1, T_DST[i], T_SRC[i], T_ESZ[i], T_WIDE[i]);
            @(posedge clk);
            #1;
            chk(T_REQ[i], out_result, T_EXP[i]);
            chk({T_REQ[i], " R8 flag"}, {127'b0, out_bad_size}, {127'b0, T_BAD[i]});
            chk("R9 valid", {127'b0, out_valid}, 128'h1);
        end

        // idle cycle: no valid output (R9)
        @(negedge clk);
        drive(1'b0, '1, '0, 2'b00, 1'b1);
        @(posedge clk);
        #1;
        chk("R9 idle", {127'b0, out_valid}, 128'h0);

        // R5 extreme bytes: 80 vs 7F -> 00 ; 7F vs 80 -> FF, alternating
        @(negedge clk);
        drive(1'b1, {8{16'h807F}}, {8{16'h7F80}}, 2'b00, 1'b1);
        @(posedge clk);
        #1;
        chk("R5 bytes", out_result, {8{16'h00FF}});

        // R6: upper operand halves differ strongly but must be ignored at 64-bit width
        @(negedge clk);
        drive(1'b1, {64'h7FFFFFFF7FFFFFFF, 64'h0000000100000000}, {64'h8000000080000000, 64'h0000000000000001}, 2'b10, 1'b0);
        @(posedge clk);
        #1;
        chk("R6 R3 narrow", out_result, {64'h0, 64'hFFFFFFFF00000000});

        // R8 at 64-bit width, then R8 flag clears on a valid size
        @(negedge clk);
        drive(1'b1, '1, '0, 2'b11, 1'b0);
        @(posedge clk);
        #1;
        chk("R8 narrow rsvd", {out_result[127:1], out_bad_size}, 128'h1);
        @(negedge clk);
        drive(1'b1, {16{8'h05}}, {16{8'h04}}, 2'b00, 1'b1);
        @(posedge clk);
        #1;
        chk("R8 R1 clear", {out_result[127:1], out_bad_size}, {{16{8'hFF}}} & ~128'h1);

        // R10: reset mid-stream clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R10 midstream", {out_result[127:1], out_valid}, 128'h0);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, '0, '0, 2'b00, 1'b1);
        @(posedge clk);
        #1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule